// File: doc/BRIEF.md
# Cache-Line-Aware Write Burst Planner

This block turns one DMA write request, given as a dword-aligned byte start address and a length in dwords, into an ordered list of bus burst descriptors. Each descriptor carries a command code, a start address and a length in dwords. The block picks the plain memory write command or the memory write and invalidate command for each burst. The choice depends on a programmable cache line size and on where the current address sits relative to a line boundary.

A misaligned start is first drained with a plain write that ends exactly on the next line boundary. From that boundary on, the block emits one invalidate burst covering the largest whole number of lines that fit in what is left. Anything still left after that, which is less than a line, goes out as a final plain write. The invalidate command is allowed only when the bus-mode flag selects conventional PCI. It is also turned off when the line size is not a power of two from 1 to 128 dwords. With invalidate off, the whole request goes out as one plain write.

Requests use a valid/ready handshake that is ready only while the block is idle. Descriptors leave on a second valid/ready handshake. A descriptor waiting for acceptance is held unchanged under back-pressure. The next descriptor is formed only after the current one is accepted. The line size and mode are captured when a request is accepted.

Top module: `wr_burst_planner`

## Requirements
- R1: After reset, req_ready is 1, desc_valid is 0 and done is 0.
- R2: When invalidate is enabled and the current dword address is not a multiple of the line size, the descriptor uses command 4'b0111. Its length is the smaller of the dwords left to the next line boundary and the dwords remaining, so it never crosses that boundary.
- R3: When invalidate is enabled, the current address is line-aligned and at least one full line remains, the descriptor uses command 4'b1111. Its length is the remaining count rounded down to a multiple of the line size.
- R4: When the current address is line-aligned and fewer dwords than one line remain, those dwords go out as one descriptor with command 4'b0111.
- R5: When cfg_pci_mode is 0 at request acceptance, no descriptor uses 4'b1111, and the whole request is one 4'b0111 descriptor.
- R6: A line size of 0, a value that is not a power of two, or a value above 128 disables invalidate. The request is then one 4'b0111 descriptor.
- R7: While desc_valid is 1 and desc_ready is 0, desc_valid stays 1 and desc_cmd, desc_addr and desc_len hold their values. Address and remaining count advance only on acceptance.
- R8: req_ready is 0 while a request is being split. A req_valid presented then is ignored and does not change the descriptor stream.
- R9: done is 1 for exactly one cycle, in the cycle after the final descriptor is accepted. A zero-length request produces no descriptor and raises done in the cycle after its acceptance.
- R10: Changing cfg_line_dw or cfg_pci_mode while a request is in progress does not affect that request's descriptors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | 32 | Start byte address, bits [1:0] zero |
| req_len | input | 16 | Transfer length in dwords |
| cfg_line_dw | input | 8 | Cache line size in dwords |
| cfg_pci_mode | input | 1 | 1 = conventional PCI (invalidate allowed) |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Descriptor accepted by the consumer |
| desc_cmd | output | 4 | 4'b0111 plain write, 4'b1111 write and invalidate |
| desc_addr | output | 32 | Burst start byte address |
| desc_len | output | 16 | Burst length in dwords |
| done | output | 1 | One-cycle pulse when the request is finished |

## Verification
The first descriptor is visible one cycle after the request handshake. Each following descriptor is visible in the cycle right after the previous one is accepted. done rises one cycle after the final acceptance, or one cycle after a zero-length request is taken. The bench drives and samples on the falling edge, so every check reads the value registered at the rising edge just before it. Holds under back-pressure are checked over several consecutive falling edges, and after each done the bench confirms that no extra descriptor follows.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  localparam logic [3:0] CMD_PLAIN = 4'b0111;
  localparam logic [3:0] CMD_INVAL = 4'b1111;

  typedef enum logic {
    PL_IDLE,
    PL_RUN
  } pl_state_e;
endpackage

// File: rtl/wbp_line_decode.sv
module wbp_line_decode #(
  parameter int CLS_W       = 8,
  parameter int MAX_LINE_DW = 128
) (
  input  logic [CLS_W-1:0] line_dw,
  input  logic             pci_mode,
  output logic             inval_en,
  output logic [CLS_W-1:0] line_mask
);
  logic pow2;

  always_comb begin
    pow2      = (line_dw != '0) && ((line_dw & (line_dw - 1'b1)) == '0);
    line_mask = line_dw - 1'b1;
    inval_en  = pci_mode && pow2 && (int'(line_dw) <= MAX_LINE_DW);
  end
endmodule

// File: rtl/wbp_burst_calc.sv
module wbp_burst_calc
  import wbp_pkg::*;
#(
  parameter int DW_ADDR_W = 30,
  parameter int LEN_W     = 16,
  parameter int CLS_W     = 8
) (
  input  logic [DW_ADDR_W-1:0] cur_dw,
  input  logic [LEN_W-1:0]     remain,
  input  logic [CLS_W-1:0]     line_dw,
  input  logic [CLS_W-1:0]     line_mask,
  input  logic                 inval_en,
  output logic [3:0]           cmd,
  output logic [LEN_W-1:0]     len
);
  localparam int PADW = (LEN_W > CLS_W) ? LEN_W - CLS_W : 0;

  logic [CLS_W-1:0] offset;
  logic [CLS_W-1:0] to_edge;
  logic [LEN_W-1:0] to_edge_w;
  logic [LEN_W-1:0] mask_w;
  logic [LEN_W-1:0] whole;

  generate
    if (LEN_W > CLS_W) begin : g_wide
      assign to_edge_w = {{PADW{1'b0}}, to_edge};
      assign mask_w    = {{PADW{1'b0}}, line_mask};
    end else begin : g_narrow
      assign to_edge_w = to_edge[LEN_W-1:0];
      assign mask_w    = line_mask[LEN_W-1:0];
    end
  endgenerate

  always_comb begin
    offset  = cur_dw[CLS_W-1:0] & line_mask;
    to_edge = line_dw - offset;
    whole   = remain & ~mask_w;
    cmd     = CMD_PLAIN;
    len     = remain;
    if (inval_en) begin
      if (offset != '0) begin
        len = (remain < to_edge_w) ? remain : to_edge_w;
      end else if (whole != '0) begin
        cmd = CMD_INVAL;
        len = whole;
      end
    end
  end
endmodule

// File: rtl/wr_burst_planner.sv
module wr_burst_planner
  import wbp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CLS_W       = 8,
  parameter int MAX_LINE_DW = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [CLS_W-1:0]  cfg_line_dw,
  input  logic              cfg_pci_mode,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [3:0]        desc_cmd,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [LEN_W-1:0]  desc_len,
  output logic              done
);
  localparam int DW_ADDR_W = ADDR_W - 2;
  localparam int PADW      = (DW_ADDR_W > LEN_W) ? DW_ADDR_W - LEN_W : 0;

  pl_state_e            state_q;
  logic [DW_ADDR_W-1:0] cur_dw_q;
  logic [LEN_W-1:0]     remain_q;
  logic [CLS_W-1:0]     line_q;
  logic                 pci_q;
  logic                 done_q;

  logic                 inval_en;
  logic [CLS_W-1:0]     line_mask;
  logic [3:0]           calc_cmd;
  logic [LEN_W-1:0]     calc_len;
  logic [DW_ADDR_W-1:0] step_dw;
  logic                 req_take;
  logic                 desc_take;

  wbp_line_decode #(
    .CLS_W       (CLS_W),
    .MAX_LINE_DW (MAX_LINE_DW)
  ) line_dec_i (
    .line_dw   (line_q),
    .pci_mode  (pci_q),
    .inval_en  (inval_en),
    .line_mask (line_mask)
  );

  wbp_burst_calc #(
    .DW_ADDR_W (DW_ADDR_W),
    .LEN_W     (LEN_W),
    .CLS_W     (CLS_W)
  ) calc_i (
    .cur_dw    (cur_dw_q),
    .remain    (remain_q),
    .line_dw   (line_q),
    .line_mask (line_mask),
    .inval_en  (inval_en),
    .cmd       (calc_cmd),
    .len       (calc_len)
  );

  generate
    if (DW_ADDR_W > LEN_W) begin : g_step_wide
      assign step_dw = {{PADW{1'b0}}, calc_len};
    end else begin : g_step_narrow
      assign step_dw = calc_len[DW_ADDR_W-1:0];
    end
  endgenerate

  assign req_ready  = (state_q == PL_IDLE);
  assign desc_valid = (state_q == PL_RUN);
  assign desc_cmd   = calc_cmd;
  assign desc_len   = calc_len;
  assign desc_addr  = {cur_dw_q, 2'b00};
  assign done       = done_q;
  assign req_take   = req_valid && req_ready;
  assign desc_take  = desc_valid && desc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= PL_IDLE;
      cur_dw_q <= '0;
      remain_q <= '0;
      line_q   <= '0;
      pci_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (req_take) begin
        cur_dw_q <= req_addr[ADDR_W-1:2];
        remain_q <= req_len;
        line_q   <= cfg_line_dw;
        pci_q    <= cfg_pci_mode;
        if (req_len == '0) begin
          done_q <= 1'b1;
        end else begin
          state_q <= PL_RUN;
        end
      end else if (desc_take) begin
        cur_dw_q <= cur_dw_q + step_dw;
        remain_q <= remain_q - calc_len;
        if (remain_q == calc_len) begin
          state_q <= PL_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_cmd)
                                     && $stable(desc_addr) && $stable(desc_len)));

  // R3
  inval_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_cmd == CMD_INVAL) |->
      (((desc_addr[CLS_W+1:2] & (line_q - 1'b1)) == '0)
       && ((desc_len[CLS_W-1:0] & (line_q - 1'b1)) == '0) && (desc_len != '0)));

  // R5
  inval_pci_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_cmd == CMD_INVAL) |-> pci_q);

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> !req_ready);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  nonzero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_len != '0));
endmodule

// File: tb/wr_burst_planner_tb_top.sv
module wr_burst_planner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic [7:0]  cfg_line_dw = '0;
  logic        cfg_pci_mode = 1'b0;
  logic        desc_valid;
  logic        desc_ready = 1'b0;
  logic [3:0]  desc_cmd;
  logic [31:0] desc_addr;
  logic [15:0] desc_len;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  localparam logic [3:0] MW  = 4'b0111;
  localparam logic [3:0] MWI = 4'b1111;

  always #2.5 clk = ~clk;

  wr_burst_planner dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .cfg_line_dw(cfg_line_dw),
    .cfg_pci_mode(cfg_pci_mode), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_cmd(desc_cmd), .desc_addr(desc_addr), .desc_len(desc_len), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic start_req(input logic [31:0] a, input logic [15:0] l,
                           input logic [7:0] cls, input logic pci, input string req);
    @(negedge clk);
    chk(req_ready == 1'b1, req, "req_ready before request", req_ready, 1);
    req_addr = a; req_len = l; cfg_line_dw = cls; cfg_pci_mode = pci;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Checks the descriptor on view now and accepts it.
  task automatic take_desc(input logic [3:0] c, input logic [31:0] a,
                           input logic [15:0] l, input string req);
    chk(desc_valid == 1'b1, req, "desc_valid", desc_valid, 1);
    chk(desc_cmd == c, req, "desc_cmd", desc_cmd, c);
    chk(desc_addr == a, req, "desc_addr", desc_addr, a);
    chk(desc_len == l, req, "desc_len", desc_len, l);
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0;
  endtask

  // Called one falling edge after the final acceptance.
  task automatic expect_done(input string req);
    chk(done == 1'b1, req, "done after last descriptor", done, 1);
    chk(desc_valid == 1'b0, req, "no descriptor after done", desc_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, req, "done lasts one cycle", done, 0);
    chk(desc_valid == 1'b0, req, "stream stays empty", desc_valid, 0);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(desc_valid == 1'b0, "R1", "desc_valid", desc_valid, 0);
    chk(done == 1'b0, "R1", "done", done, 0);
  endtask

  task automatic t_head_body_tail();
    // R2 R3 R4: line 8, dword offset 5, 30 dwords -> 3 / 24 / 3
    start_req(32'h1014, 16'd30, 8'd8, 1'b1, "R2");
    take_desc(MW,  32'h1014, 16'd3,  "R2");
    take_desc(MWI, 32'h1020, 16'd24, "R3");
    take_desc(MW,  32'h1080, 16'd3,  "R4");
    expect_done("R9");
  endtask

  task automatic t_aligned_exact();
    start_req(32'h2000, 16'd32, 8'd16, 1'b1, "R3");
    take_desc(MWI, 32'h2000, 16'd32, "R3");
    expect_done("R9");
  endtask

  task automatic t_aligned_short();
    start_req(32'h3000, 16'd5, 8'd16, 1'b1, "R4");
    take_desc(MW, 32'h3000, 16'd5, "R4");
    expect_done("R9");
  endtask

  task automatic t_unaligned_short();
    start_req(32'h4004, 16'd4, 8'd8, 1'b1, "R2");
    take_desc(MW, 32'h4004, 16'd4, "R2");
    expect_done("R9");
  endtask

  task automatic t_non_pci();
    start_req(32'h1014, 16'd30, 8'd8, 1'b0, "R5");
    take_desc(MW, 32'h1014, 16'd30, "R5");
    expect_done("R5");
  endtask

  task automatic t_bad_line();
    start_req(32'h5000, 16'd48, 8'd12, 1'b1, "R6");
    take_desc(MW, 32'h5000, 16'd48, "R6");
    expect_done("R6");
    start_req(32'h5000, 16'd48, 8'd0, 1'b1, "R6");
    take_desc(MW, 32'h5000, 16'd48, "R6");
    expect_done("R6");
    start_req(32'h5000, 16'd512, 8'd255, 1'b1, "R6");
    take_desc(MW, 32'h5000, 16'd512, "R6");
    expect_done("R6");
  endtask

  task automatic t_stall_and_busy();
    // line 4, dword offset 2, 10 dwords -> 2 plain, 8 invalidate
    start_req(32'h6008, 16'd10, 8'd4, 1'b1, "R7");
    for (int i = 0; i < 3; i++) begin
      chk(desc_valid && desc_cmd == MW && desc_addr == 32'h6008 && desc_len == 16'd2,
          "R7", "held descriptor", {desc_cmd, desc_addr, desc_len}, {MW, 32'h6008, 16'd2});
      chk(req_ready == 1'b0, "R8", "req_ready while busy", req_ready, 0);
      // R8: offer a competing request; R10: change config mid-transfer
      req_valid = 1'b1; req_addr = 32'h9000; req_len = 16'd7;
      cfg_line_dw = 8'd0; cfg_pci_mode = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    take_desc(MW,  32'h6008, 16'd2, "R7");
    take_desc(MWI, 32'h6010, 16'd8, "R10");
    expect_done("R8");
  endtask

  task automatic t_zero_len();
    start_req(32'h7000, 16'd0, 8'd8, 1'b1, "R9");
    // start_req returns one falling edge after acceptance
    chk(done == 1'b1, "R9", "done for zero length", done, 1);
    chk(desc_valid == 1'b0, "R9", "no descriptor for zero length", desc_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "zero-length done one cycle", done, 0);
    chk(desc_valid == 1'b0, "R9", "still no descriptor", desc_valid, 0);
  endtask

  task automatic t_edge_lines();
    start_req(32'h7004, 16'd3, 8'd1, 1'b1, "R3");
    take_desc(MWI, 32'h7004, 16'd3, "R3");
    expect_done("R9");
    start_req(32'h8000, 16'd300, 8'd128, 1'b1, "R3");
    take_desc(MWI, 32'h8000, 16'd256, "R3");
    take_desc(MW,  32'h8400, 16'd44,  "R4");
    expect_done("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_head_body_tail();
    t_aligned_exact();
    t_aligned_short();
    t_unaligned_short();
    t_non_pci();
    t_bad_line();
    t_stall_and_busy();
    t_zero_len();
    t_edge_lines();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule